// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the four-beat address stream of a synchronous burst memory. When the start strobe is low at a rising clock edge, the block captures a full starting address and the ordering mode. From the next cycle it presents that address. After that, each rising edge on which the advance input is low moves the output to the next beat of the burst. An edge on which advance is high leaves the output where it is.

Only the two low address bits take part in the sequence. They can follow one of two orders:

- **Linear:** the low bits wrap around upward from the starting value.
- **Interleaved:** the low bits are the starting value XORed with the beat number.

The upper bits of the captured address stay as they were for the whole burst. A memory controller drives the strobe together with the first address, then holds advance low for as many beats as it needs. It can restart the burst at any cycle with a new strobe.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addrOut` is all zeros.
- R2: A rising edge with `startN` low captures `addrIn`, and `addrOut` equals it from the following cycle (beat 0).
- R3: With `interleave` low at capture (linear order), each edge with `advN` low and `startN` high adds 1 modulo 4 to `addrOut[1:0]`. For example, a start of 1 gives 1,2,3,0.
- R4: With `interleave` high at capture (interleaved order), `addrOut[1:0]` at beat k (k = 0..3) equals the start low bits XOR k. For example, a start of 1 gives 1,0,3,2.
- R5: An edge with both `startN` and `advN` high leaves `addrOut` unchanged (burst suspend).
- R6: A strobe in any cycle, including mid-burst and with `advN` low, reloads the address and restarts the beat count at 0.
- R7: `addrOut[ADDR_W-1:2]` stays at the captured upper bits for the whole burst. No carry enters it from the low bits, and `addrIn` is ignored while `startN` is high.
- R8: After the fourth beat, a further advance wraps the beat count to 0, which returns the starting address.
- R9: The ordering mode is taken only at the strobe edge. Changing `interleave` mid-burst has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| startN | input | 1 | Active-low start strobe; loads address and mode |
| advN | input | 1 | Active-low advance to the next beat |
| interleave | input | 1 | Ordering mode: 0 linear, 1 interleaved |
| addrIn | input | ADDR_W | Starting address presented with the strobe |
| addrOut | output | ADDR_W | Current burst address |

## Verification
The following are checked on every cycle by assertions:

- the beat counter clears on a strobe, steps modulo 4 on an advance and holds on a suspend;
- a strobe makes the output equal the presented address;
- the upper bits keep their value between strobes;
- the change in the low output bits matches the change in the beat count, by difference in linear order and by XOR in interleaved order.

Only the bench scenarios show the following:

- the actual sequences produced from different start offsets;
- the wrap back to the first beat;
- that a mid-burst mode change is ignored;
- that a restart issued while advancing takes effect;
- the value present right after reset.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEAT_W = 2;

  typedef struct packed {
    logic              load;
    logic [BEAT_W-1:0] beat;
  } seqCtl_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startN,
  input  logic    advN,
  output seqCtl_t ctl
);
  logic [BEAT_W-1:0] beatQ;

  always_ff @(posedge clk) begin
    if (!rstN)        beatQ <= '0;
    else if (!startN) beatQ <= '0;
    else if (!advN)   beatQ <= beatQ + 1'b1;
  end

  assign ctl.load = !startN;
  assign ctl.beat = beatQ;

  // R6: a strobe restarts the beat count
  p_restart_r6: assert property (@(posedge clk) disable iff (!rstN)
    !startN |=> (beatQ == '0));

  // R8: advance steps the count with wrap
  p_wrap_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (startN && !advN) |=> (beatQ == BEAT_W'($past(beatQ) + 1'b1)));

  // R5: suspend holds the count
  p_suspend_r5: assert property (@(posedge clk) disable iff (!rstN)
    (startN && advN) |=> $stable(beatQ));
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic [UP_W-1:0]   upperQ;
  logic [BEAT_W-1:0] startLowQ;
  logic              modeQ;
  logic [BEAT_W-1:0] lowOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperQ    <= '0;
      startLowQ <= '0;
      modeQ     <= 1'b0;
    end else if (ctl.load) begin
      upperQ    <= addrIn[ADDR_W-1:BEAT_W];
      startLowQ <= addrIn[BEAT_W-1:0];
      modeQ     <= interleave;
    end
  end

  always_comb begin
    if (modeQ) lowOut = startLowQ ^ ctl.beat;
    else       lowOut = startLowQ + ctl.beat;
  end

  assign addrOut = {upperQ, lowOut};

  // R2: strobe presents the captured address next cycle
  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (addrOut == $past(addrIn)));

  // R7: upper bits fixed between strobes
  p_upper_fixed_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(addrOut[ADDR_W-1:BEAT_W]));

  // R3: linear order tracks the beat count by difference
  p_linear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !modeQ) |=>
      (BEAT_W'(addrOut[BEAT_W-1:0] - $past(addrOut[BEAT_W-1:0])) ==
       BEAT_W'(ctl.beat - $past(ctl.beat))));

  // R4: interleaved order tracks the beat count by XOR
  p_interleave_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && modeQ) |=>
      ((addrOut[BEAT_W-1:0] ^ $past(addrOut[BEAT_W-1:0])) ==
       (ctl.beat ^ $past(ctl.beat))));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startN,
  input  logic              advN,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut
);
  seqCtl_t ctl;

  burst_seq_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .startN (startN),
    .advN   (advN),
    .ctl    (ctl)
  );

  burst_seq_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .interleave (interleave),
    .addrIn     (addrIn),
    .addrOut    (addrOut)
  );
endmodule

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rstN, startN, advN, interleave;
  logic [AW-1:0] addrIn, addrOut;
  int            total = 0, failed = 0;
  bit            done = 0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .startN(startN), .advN(advN),
    .interleave(interleave), .addrIn(addrIn), .addrOut(addrOut)
  );

  function automatic logic [AW-1:0] expAddr(logic [AW-1:0] b, logic m, int k);
    logic [1:0] kk = 2'(k);
    logic [1:0] lo = m ? (b[1:0] ^ kk) : 2'(b[1:0] + kk);
    return {b[AW-1:2], lo};
  endfunction

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: addrOut=%h expected %h", req, act, exp);
    end
  endtask

  // apply inputs at a falling edge, return after the next falling edge
  task automatic tick(logic s, logic a, logic [AW-1:0] ad, logic m);
    startN = s; advN = a; addrIn = ad; interleave = m;
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R1", addrOut, '0);
  endtask

  task automatic testBurst(logic [AW-1:0] b, logic m);
    tick(1'b0, 1'b1, b, m);
    check("R2", addrOut, b);
    for (int k = 1; k <= 4; k++) begin
      tick(1'b1, 1'b0, ~b, m);
      check(k == 4 ? "R8" : (m ? "R4" : "R3"), addrOut, expAddr(b, m, k));
    end
  endtask

  task automatic testSuspend();
    logic [AW-1:0] b = 18'h00AB2;
    tick(1'b0, 1'b1, b, 1'b0);
    tick(1'b1, 1'b0, '0, 1'b0);
    for (int i = 0; i < 2; i++) begin
      tick(1'b1, 1'b1, 18'h3FFFF, 1'b1);
      check("R5", addrOut, expAddr(b, 1'b0, 1));
    end
    tick(1'b1, 1'b0, '0, 1'b0);
    check("R5", addrOut, expAddr(b, 1'b0, 2));
  endtask

  task automatic testRestart();
    logic [AW-1:0] a = 18'h12340, b = 18'h05551;
    tick(1'b0, 1'b1, a, 1'b0);
    tick(1'b1, 1'b0, '0, 1'b0);
    tick(1'b1, 1'b0, '0, 1'b0);
    tick(1'b0, 1'b0, b, 1'b1);
    check("R6", addrOut, b);
    tick(1'b1, 1'b0, '0, 1'b0);
    check("R6", addrOut, expAddr(b, 1'b1, 1));
  endtask

  task automatic testModeLatch();
    logic [AW-1:0] b = 18'h2A001;
    tick(1'b0, 1'b1, b, 1'b0);
    for (int k = 1; k <= 3; k++) begin
      tick(1'b1, 1'b0, '0, 1'b1);
      check("R9", addrOut, expAddr(b, 1'b0, k));
    end
  endtask

  task automatic testUpper();
    logic [AW-1:0] b = 18'h3FFFF;
    tick(1'b0, 1'b1, b, 1'b0);
    for (int k = 1; k <= 3; k++) begin
      tick(1'b1, 1'b0, 18'h00000, 1'b0);
      check("R7", addrOut, {16'hFFFF, 2'(3 + k)});
    end
  endtask

  initial begin
    rstN = 1'b0; startN = 1'b1; advN = 1'b1; interleave = 1'b0; addrIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBurst(18'h10005, 1'b0);
    testBurst(18'h10005, 1'b1);
    testBurst(18'h0C003, 1'b0);
    testBurst(18'h0C003, 1'b1);
    testSuspend();
    testRestart();
    testModeLatch();
    testUpper();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; failed++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule